// File: doc/BRIEF.md
# Morse Letter Flasher

This block turns a three-bit letter code into the Morse pattern for that letter, played on one LED output. A start pushbutton launches playback of whichever letter the switches select at that moment. Letters A through H are covered, each made of one to four symbols. Every dot, dash and gap is a whole number of slow timing ticks. Those ticks come from a prescaler on the fast system clock.

A sequencer does the work in three steps. It looks up the symbol pattern and symbol count of the chosen letter. It then lights the LED for each symbol in turn, with a dark gap after every symbol. After the gap that follows the last symbol, it returns to idle. The tick divisor is a parameter: 25,000,000 gives half-second ticks from a 50 MHz clock, and a small value suits simulation.

Top module: `morse_letter_tx`

## Requirements
- R1: While `rst_ni` is low the LED is off and the sequencer is idle. The reset acts asynchronously, without waiting for a clock edge.
- R2: Letter codes select letters in order: 0 = A, 1 = B, and so on up to 7 = H. Each letter plays its symbols first to last, with `.` meaning dot and `-` meaning dash: A `.-`, B `-...`, C `-.-.`, D `-..`, E `.`, F `..-.`, G `--.`, H `....`.
- R3: A dot holds `led_o` high for exactly TICK_DIV clock cycles.
- R4: A dash holds `led_o` high for exactly 3*TICK_DIV clock cycles.
- R5: Every symbol, the last one included, is followed by exactly TICK_DIV cycles with `led_o` low. After the gap that follows the last symbol, the block is idle.
- R6: `start_i` passes through a two-flop synchroniser and only its rising edge counts. The first symbol starts at the second rising clock edge after the edge that first samples `start_i` high. Holding the button down does not restart playback.
- R7: The letter code is captured when a start is accepted. Changing `letter_i` during playback has no effect on the output.
- R8: Start presses that arrive while a letter is playing are ignored, and no extra letter follows.
- R9: The prescaler restarts whenever a symbol or gap begins. As a result, the length of every phase does not depend on when the button was pressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| letter_i | input | 3 | Letter code, 0 = A through 7 = H |
| start_i | input | 1 | Start pushbutton, asynchronous, active high |
| led_o | output | 1 | LED drive, high while a dot or dash is shown |

## Verification
Several properties are checked on every cycle:
- every lit run lasts either one tick period or three;
- every gap lasts exactly one tick period;
- leaving idle always follows an accepted start edge;
- the captured pattern stays fixed during playback;
- the tick is a single-cycle pulse.

Other behaviours show only in the bench scenarios, which compare the LED cycle by cycle against a behavioural model. These are the symbol order of each of the eight letters, the start latency, immunity to switch changes and repeated presses, a held button, and a reset that arrives in the middle of a letter.

// File: rtl/morse_pkg.sv
package morse_pkg;
  localparam int unsigned MAX_SYM    = 4;
  localparam int unsigned SYM_W      = $clog2(MAX_SYM);
  localparam int unsigned DASH_TICKS = 3;
  localparam int unsigned REM_W      = $clog2(DASH_TICKS);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MARK = 2'd1,
    ST_GAP  = 2'd2
  } seq_state_e;

  // dash[i] = 1 means symbol i is a dash; len is the symbol count (1..MAX_SYM)
  typedef struct packed {
    logic [MAX_SYM-1:0] dash;
    logic [SYM_W:0]     len;
  } letter_t;
endpackage

// File: rtl/morse_sync_edge.sv
module morse_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/morse_tick_gen.sv
module morse_tick_gen #(
  parameter int unsigned DIV = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (restart_i || tick_o) cnt_q <= '0;
    else                          cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/morse_pattern_rom.sv
module morse_pattern_rom
  import morse_pkg::*;
(
  input  logic [2:0] letter_i,
  output letter_t    entry_o
);
  // bit i of dash = symbol i, first symbol in bit 0
  always_comb begin
    unique case (letter_i)
      3'd0:    entry_o = '{dash: 4'b0010, len: 3'd2}; // A .-
      3'd1:    entry_o = '{dash: 4'b0001, len: 3'd4}; // B -...
      3'd2:    entry_o = '{dash: 4'b0101, len: 3'd4}; // C -.-.
      3'd3:    entry_o = '{dash: 4'b0001, len: 3'd3}; // D -..
      3'd4:    entry_o = '{dash: 4'b0000, len: 3'd1}; // E .
      3'd5:    entry_o = '{dash: 4'b0100, len: 3'd4}; // F ..-.
      3'd6:    entry_o = '{dash: 4'b0011, len: 3'd3}; // G --.
      default: entry_o = '{dash: 4'b0000, len: 3'd4}; // H ....
    endcase
  end
endmodule

// File: rtl/morse_seq_fsm.sv
module morse_seq_fsm
  import morse_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       press_i,
  input  logic       tick_i,
  input  letter_t    entry_i,
  output seq_state_e state_o,
  output letter_t    pat_o,
  output logic       restart_o
);
  localparam logic [REM_W-1:0] DASH_REM = REM_W'(DASH_TICKS - 1);

  seq_state_e       state_q, state_d;
  letter_t          pat_q, pat_d;
  logic [SYM_W-1:0] idx_q, idx_d;
  logic [REM_W-1:0] rem_q, rem_d;
  logic [SYM_W-1:0] idx_nxt;
  logic [SYM_W:0]   done_cnt;

  assign idx_nxt  = idx_q + 1'b1;
  assign done_cnt = {1'b0, idx_q} + 1'b1;

  always_comb begin
    state_d   = state_q;
    pat_d     = pat_q;
    idx_d     = idx_q;
    rem_d     = rem_q;
    restart_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (press_i) begin
        state_d   = ST_MARK;
        pat_d     = entry_i;
        idx_d     = '0;
        rem_d     = entry_i.dash[0] ? DASH_REM : '0;
        restart_o = 1'b1;
      end
      ST_MARK: if (tick_i) begin
        if (rem_q == '0) begin
          state_d   = ST_GAP;
          restart_o = 1'b1;
        end else begin
          rem_d = rem_q - 1'b1;
        end
      end
      ST_GAP: if (tick_i) begin
        restart_o = 1'b1;
        if (done_cnt == pat_q.len) begin
          state_d = ST_IDLE;
        end else begin
          state_d = ST_MARK;
          idx_d   = idx_nxt;
          rem_d   = pat_q.dash[idx_nxt] ? DASH_REM : '0;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pat_q   <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
    end else begin
      state_q <= state_d;
      pat_q   <= pat_d;
      idx_q   <= idx_d;
      rem_q   <= rem_d;
    end
  end

  assign state_o = state_q;
  assign pat_o   = pat_q;
endmodule

// File: rtl/morse_letter_tx.sv
module morse_letter_tx
  import morse_pkg::*;
#(
  parameter int unsigned TICK_DIV    = 25_000_000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] letter_i,
  input  logic       start_i,
  output logic       led_o
);
  logic       press;
  logic       tick;
  logic       restart;
  letter_t    entry;
  letter_t    pat_q;
  seq_state_e seq_state;

  morse_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(start_i),
    .rise_o (press)
  );

  morse_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .tick_o   (tick)
  );

  morse_pattern_rom u_rom (
    .letter_i(letter_i),
    .entry_o (entry)
  );

  morse_seq_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .press_i  (press),
    .tick_i   (tick),
    .entry_i  (entry),
    .state_o  (seq_state),
    .pat_o    (pat_q),
    .restart_o(restart)
  );

  assign led_o = (seq_state == ST_MARK);
endmodule

// File: rtl/morse_letter_chk.sv
module morse_letter_chk
  import morse_pkg::*;
#(
  parameter int unsigned TICK_DIV = 25_000_000
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       led_o,
  input seq_state_e state_i,
  input logic       tick_i,
  input logic       press_i,
  input letter_t    pat_i
);
  logic [31:0] on_run, gap_run;
  logic        past_ok_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      on_run    <= '0;
      gap_run   <= '0;
      past_ok_q <= 1'b0;
    end else begin
      on_run    <= led_o ? on_run + 1 : '0;
      gap_run   <= (state_i == ST_GAP) ? gap_run + 1 : '0;
      past_ok_q <= 1'b1;
    end
  end

  p_reset_dark_r1: assert property (@(posedge clk_i) !rst_ni |-> !led_o);

  // R3 and R4: each lit run is one dot or one dash long
  p_mark_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $fell(led_o)) |->
      (on_run == TICK_DIV || on_run == DASH_TICKS * TICK_DIV));

  p_gap_len_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(state_i) == ST_GAP && state_i != ST_GAP) |->
      (gap_run == TICK_DIV));

  p_start_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(state_i) == ST_IDLE && state_i != ST_IDLE) |->
      $past(press_i));

  p_latched_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && $past(state_i) != ST_IDLE && state_i != ST_IDLE) |->
      $stable(pat_i));

  generate
    if (TICK_DIV > 1) begin : g_tick
      p_tick_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_i |=> !tick_i);
    end
  endgenerate
endmodule

bind morse_letter_tx morse_letter_chk #(.TICK_DIV(TICK_DIV)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .led_o  (led_o),
  .state_i(seq_state),
  .tick_i (tick),
  .press_i(press),
  .pat_i  (pat_q)
);

// File: tb/morse_letter_tx_bench.sv
`timescale 1ns/1ps
module morse_letter_tx_bench;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] letter = 3'd0;
  logic       start = 1'b0;
  logic       led;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  morse_letter_tx #(.TICK_DIV(N)) u_morse_letter_tx (
    .clk_i(clk), .rst_ni(rst_n), .letter_i(letter), .start_i(start), .led_o(led)
  );

  always #2 clk = ~clk;

  // R2 symbol strings, taken straight from the requirement
  function automatic string sym_str(input logic [2:0] l);
    case (l)
      3'd0: return ".-";
      3'd1: return "-...";
      3'd2: return "-.-.";
      3'd3: return "-..";
      3'd4: return ".";
      3'd5: return "..-.";
      3'd6: return "--.";
      default: return "....";
    endcase
  endfunction

  // behavioural reference model
  bit    m_busy, m_mark;
  int    m_left, m_pos;
  string m_pat;
  bit [2:0] m_hist;
  bit    m_press;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_mark = 0; m_hist = '0; m_left = 0; m_pos = 0;
    end else begin
      m_press = m_hist[1] && !m_hist[2];
      m_hist  = {m_hist[1:0], start};
      if (!m_busy) begin
        if (m_press) begin
          m_pat  = sym_str(letter);
          m_pos  = 0;
          m_busy = 1;
          m_mark = 1;
          m_left = (m_pat[0] == "-") ? 3 * N : N;
        end
      end else begin
        m_left--;
        if (m_left == 0) begin
          if (m_mark) begin
            m_mark = 0;
            m_left = N;
          end else begin
            m_pos++;
            if (m_pos >= m_pat.len()) m_busy = 0;
            else begin
              m_mark = 1;
              m_left = (m_pat[m_pos] == "-") ? 3 * N : N;
            end
          end
        end
      end
    end
  end

  task automatic check(input bit got, input bit exp, input string req);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: led=%0b expected %0b at %0t", req, got, exp, $time);
    end
  endtask

  // per-cycle compare, tagged by phase: R3 dot, R4 dash, R5 gap/idle
  always @(negedge clk) begin
    if (rst_n) begin
      string ph;
      if (!m_busy) ph = "R5";
      else if (!m_mark) ph = "R5";
      else ph = (m_pat[m_pos] == "-") ? "R4" : "R3";
      check(led, m_busy && m_mark, {cur_req, "/", ph});
    end
  end

  task automatic press(input logic [2:0] l, input int hold);
    @(negedge clk);
    letter = l;
    start  = 1'b1;
    repeat (hold) @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (m_busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    #1 check(led, 1'b0, "R1");
    repeat (3) @(negedge clk);
    check(led, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    check(led, 1'b0, "R1");

    // R2 each letter, with R9 varied press phase
    cur_req = "R2";
    for (int l = 0; l < 8; l++) begin
      repeat (l % N) @(negedge clk);
      press(3'(l), 2);
      wait_idle();
    end

    // R6 held button plays once
    cur_req = "R6";
    press(3'd0, 60);
    wait_idle();

    // R7 switches change mid-letter
    cur_req = "R7";
    press(3'd2, 1);
    repeat (6) @(negedge clk);
    letter = 3'd4;
    repeat (20) @(negedge clk);
    letter = 3'd7;
    wait_idle();

    // R8 presses while busy ignored
    cur_req = "R8";
    press(3'd1, 2);
    repeat (8) @(negedge clk);
    for (int k = 0; k < 4; k++) begin
      press(3'd7, 2);
      repeat (5) @(negedge clk);
    end
    wait_idle();

    // R9 restart alignment with odd offsets
    cur_req = "R9";
    for (int k = 1; k < 4; k++) begin
      repeat (k) @(negedge clk);
      press(3'd6, 1);
      wait_idle();
    end

    // R1 asynchronous reset mid-letter
    cur_req = "R1";
    press(3'd7, 2);
    repeat (7) @(negedge clk);
    while (!led) @(negedge clk);
    #1 rst_n = 1'b0;
    #0.5 check(led, 1'b0, "R1");
    repeat (2) @(negedge clk);
    check(led, 1'b0, "R1");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(led, 1'b0, "R1");
    press(3'd4, 1);
    wait_idle();

    finish_run();
  end
endmodule